// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Early Warning

This block is a watchdog for a larger chip. A down-counter loses one count on each pulse of a tick input while counting is switched on. Software keeps the system alive by loading a fresh count before the counter runs out. It can also set a warning level, and it gets an early interrupt when the count falls to that level. A second interrupt fires when the count reaches zero. Both interrupt flags stay set, appear in a status word, and are cleared only by a bit mask on a dedicated clear input.

The registers sit on a simple word bus with an address, a write strobe, write data and combinational read data. A stray write must not be able to disarm or retune the watchdog, so every write to a control register must first be armed. To arm it, the unlock key 0xF1D0DEAD is written to the safety register just before. An arm covers exactly one write. A wrong key cancels it.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the count reads 0xFFFFFFFF, the threshold reads 0, the enable reads 0, both interrupts are low and the status word is zero.
- R2: The registers are selected by byte address: count 0x0, threshold 0x4, enable 0x8, safety 0xC. A write to 0x0, 0x4 or 0x8 changes state only if the most recent bus write before it put 0xF1D0DEAD into the safety register. The safety register reads as zero.
- R3: An arm is used up by the next write to a register other than safety. A second write without a new key is ignored.
- R4: Writing any value other than 0xF1D0DEAD to the safety register cancels a pending arm.
- R5: An accepted write to the count register loads the written value on the next edge, and it wins over a tick in the same cycle. Reading the count register returns the present count, with any value from 1 to 0xFFFFFFFF allowed.
- R6: Bit 0 of an accepted write to the enable register starts counting (1) or stops it (0), and the enable register reads back that bit. While counting is stopped the count does not change on ticks.
- R7: While enabled, the count drops by one on each clock with the tick input high, never changes without a tick, and stays at zero once it reaches zero.
- R8: While enabled and the count is zero, status bit 9 and the timeout interrupt output are set on the following clock edge.
- R9: While enabled and the count equals a non-zero threshold, status bit 8 and the warning interrupt output are set on the following clock edge. A threshold of zero never raises the warning.
- R10: Status bits stay set until the matching bit of the clear mask is high for a cycle. If the set condition still holds in that cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-rate pulse, one decrement per high cycle |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| stat_clr_i | input | DATA_W | Clear mask for the status word (bits 8 and 9 used) |
| status_o | output | DATA_W | Sticky status: bit 8 warning, bit 9 timeout |
| irq_warn_o | output | 1 | Early-warning interrupt |
| irq_expire_o | output | 1 | Timeout interrupt |

## Verification
The key gate is tried with four write patterns: a plain write with no key, a keyed write, a second write that reuses a spent key, and a correct key cancelled by a wrong one. Only the keyed write may change the register that is read back. The counter is driven with ticks, idle cycles and ticks while stopped, which separates real decrements from drift. Warning and timeout are checked one cycle before and one cycle after they must rise. Clears are applied both while the trigger still holds and after it has passed, which shows that a set wins over a clear. A zero threshold run shows that no warning is raised on the way down to expiry.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    localparam logic [31:0] UNLOCK_KEY = 32'hF1D0_DEAD;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_THRESH = 2'd1,
        REG_ENABLE = 2'd2,
        REG_SAFETY = 2'd3
    } reg_sel_e;

    localparam int WARN_BIT   = 8;
    localparam int EXPIRE_BIT = 9;
    localparam int N_FLAGS    = 2;
    localparam int FLAG_WARN   = 0;
    localparam int FLAG_EXPIRE = 1;

endpackage

// File: rtl/wdt_keyed_gate.sv
module wdt_keyed_gate
    import wdt_keyed_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY = DATA_W'(UNLOCK_KEY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              commit_o,
    output logic              armed_o
);

    typedef struct packed {
        logic armed;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            if (sel_i == REG_SAFETY) begin
                st_d.armed = (wdata_i == KEY);
            end else begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o = we_i && (sel_i != REG_SAFETY) && st_q.armed;
    assign armed_o  = st_q.armed;

endmodule

// File: rtl/wdt_keyed_counter.sv
module wdt_keyed_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         run_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (run_i && tick_i && (st_q.cnt != ZERO)) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/wdt_keyed_flags.sv
module wdt_keyed_flags
    import wdt_keyed_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [W-1:0]       cnt_i,
    input  logic [W-1:0]       thr_i,
    input  logic [N_FLAGS-1:0] clr_i,
    output logic [N_FLAGS-1:0] flags_o
);

    typedef struct packed {
        logic [N_FLAGS-1:0] flags;
    } flag_t;

    flag_t st_d, st_q;
    logic [N_FLAGS-1:0] evt;

    always_comb begin
        evt              = '0;
        evt[FLAG_WARN]   = run_i && (thr_i != '0) && (cnt_i == thr_i);
        evt[FLAG_EXPIRE] = run_i && (cnt_i == '0);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_FLAGS; i++) begin
            st_d.flags[i] = (st_q.flags[i] & ~clr_i[i]) | evt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [DATA_W-1:0] stat_clr_i,
    output logic [DATA_W-1:0] status_o,
    output logic              irq_warn_o,
    output logic              irq_expire_o
);

    localparam int SEL_LSB = 2;

    typedef struct packed {
        logic [DATA_W-1:0] thr;
        logic              en;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     commit;
    logic     armed;
    logic     load_cnt;
    logic [DATA_W-1:0]  cnt_w;
    logic [DATA_W-1:0]  thr_w;
    logic               en_w;
    logic [N_FLAGS-1:0] clr_w;
    logic [N_FLAGS-1:0] flags_w;

    assign sel = reg_sel_e'(bus_addr_i[SEL_LSB +: 2]);

    wdt_keyed_gate #(
        .DATA_W (DATA_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (bus_we_i),
        .sel_i    (sel),
        .wdata_i  (bus_wdata_i),
        .commit_o (commit),
        .armed_o  (armed)
    );

    always_comb begin
        regs_d = regs_q;
        if (commit && sel == REG_THRESH) begin
            regs_d.thr = bus_wdata_i;
        end
        if (commit && sel == REG_ENABLE) begin
            regs_d.en = bus_wdata_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign thr_w    = regs_q.thr;
    assign en_w     = regs_q.en;
    assign load_cnt = commit && (sel == REG_COUNT);

    wdt_keyed_counter #(
        .W (DATA_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_cnt),
        .load_val_i (bus_wdata_i),
        .run_i      (en_w),
        .tick_i     (tick_i),
        .cnt_o      (cnt_w)
    );

    always_comb begin
        clr_w              = '0;
        clr_w[FLAG_WARN]   = stat_clr_i[WARN_BIT];
        clr_w[FLAG_EXPIRE] = stat_clr_i[EXPIRE_BIT];
    end

    wdt_keyed_flags #(
        .W (DATA_W)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (en_w),
        .cnt_i   (cnt_w),
        .thr_i   (thr_w),
        .clr_i   (clr_w),
        .flags_o (flags_w)
    );

    always_comb begin
        status_o             = '0;
        status_o[WARN_BIT]   = flags_w[FLAG_WARN];
        status_o[EXPIRE_BIT] = flags_w[FLAG_EXPIRE];
    end

    assign irq_warn_o   = flags_w[FLAG_WARN];
    assign irq_expire_o = flags_w[FLAG_EXPIRE];

    always_comb begin
        unique case (sel)
            REG_COUNT:  bus_rdata_o = cnt_w;
            REG_THRESH: bus_rdata_o = thr_w;
            REG_ENABLE: bus_rdata_o = {{(DATA_W-1){1'b0}}, en_w};
            default:    bus_rdata_o = '0;
        endcase
    end

    logic unused_inputs;
    assign unused_inputs = ^{stat_clr_i, bus_addr_i, armed};

endmodule

// File: rtl/wdt_keyed_checker.sv
module wdt_keyed_checker
    import wdt_keyed_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we_i,
    input logic [1:0]        sel,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              commit,
    input logic              armed,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] thr,
    input logic              en,
    input logic              irq_warn_o,
    input logic              irq_expire_o,
    input logic              clr_warn,
    input logic              clr_expire
);

    localparam logic [DATA_W-1:0] KEY = DATA_W'(UNLOCK_KEY);

    a_r2_locked_thr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && sel == 2'd1 && !armed) |=> $stable(thr));

    a_r3_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !armed);

    a_r4_wrong_key: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && sel == 2'd3 && bus_wdata_i != KEY) |=> !armed);

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sel == 2'd0) |=> (cnt == $past(bus_wdata_i)));

    a_r6_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(commit && sel == 2'd0)) |=> $stable(cnt));

    a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !(commit && sel == 2'd0)) |=> (cnt == '0));

    a_r8_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == '0) |=> irq_expire_o);

    a_r9_no_warn_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0 && !irq_warn_o) |=> !irq_warn_o);

    a_r10_sticky_warn: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_warn_o && !clr_warn) |=> irq_warn_o);

    a_r10_sticky_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_expire_o && !clr_expire) |=> irq_expire_o);

endmodule

bind wdt_keyed wdt_keyed_checker #(
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we_i     (bus_we_i),
    .sel          (sel),
    .bus_wdata_i  (bus_wdata_i),
    .commit       (commit),
    .armed        (armed),
    .cnt          (cnt_w),
    .thr          (thr_w),
    .en           (en_w),
    .irq_warn_o   (irq_warn_o),
    .irq_expire_o (irq_expire_o),
    .clr_warn     (clr_w[0]),
    .clr_expire   (clr_w[1])
);

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;

    localparam logic [31:0] KEY = 32'hF1D0_DEAD;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_KW = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{OP_WR, 4'h0, 32'd5,         32'd0},          // R2 unkeyed count write
        '{OP_RD, 4'h0, 32'd0,         32'hFFFF_FFFF},  // R2 ignored
        '{OP_KW, 4'h0, 32'd10,        32'd0},          // R5 keyed reload
        '{OP_RD, 4'h0, 32'd0,         32'd10},         // R5 reads back
        '{OP_WR, 4'h4, 32'd3,         32'd0},          // R3 reuse of spent key
        '{OP_RD, 4'h4, 32'd0,         32'd0},          // R3 ignored
        '{OP_WR, 4'hC, KEY,           32'd0},          // R4 arm
        '{OP_WR, 4'hC, 32'h1234_5678, 32'd0},          // R4 wrong key cancels
        '{OP_WR, 4'h4, 32'd7,         32'd0},          // R4 write after cancel
        '{OP_RD, 4'h4, 32'd0,         32'd0},          // R4 ignored
        '{OP_KW, 4'h4, 32'd3,         32'd0},          // R2 keyed threshold
        '{OP_RD, 4'h4, 32'd0,         32'd3},          // R2 accepted
        '{OP_RD, 4'hC, 32'd0,         32'd0},          // R2 safety reads zero
        '{OP_KW, 4'h8, 32'd1,         32'd0},          // R6 start
        '{OP_RD, 4'h8, 32'd0,         32'd1}           // R6 enable reads back
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] clr = '0;
    logic [31:0] status;
    logic        irq_warn, irq_expire;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    wdt_keyed u_wdt_keyed (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .bus_addr_i   (addr),
        .bus_we_i     (we),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .stat_clr_i   (clr),
        .status_o     (status),
        .irq_warn_o   (irq_warn),
        .irq_expire_o (irq_expire)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic kwr(input logic [3:0] a, input logic [31:0] d);
        wr(4'hC, KEY);
        wr(a, d);
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic pulse_clr(input logic [31:0] m);
        @(negedge clk);
        clr = m;
        @(negedge clk);
        clr = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd("R1 count", 4'h0, 32'hFFFF_FFFF);
        rd("R1 threshold", 4'h4, 32'd0);
        rd("R1 enable", 4'h8, 32'd0);
        check("R1 status", status, 32'd0);
        check("R1 irqs", {30'd0, irq_warn, irq_expire}, 32'd0);

        // table of bus patterns
        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_WR: wr(TBL[i].addr, TBL[i].data);
                OP_KW: kwr(TBL[i].addr, TBL[i].data);
                default: rd($sformatf("table row %0d", i), TBL[i].addr, TBL[i].exp);
            endcase
        end

        // R7 decrement per tick, nothing on idle cycles
        pulse_tick(4);
        rd("R7 four ticks", 4'h0, 32'd6);
        repeat (5) @(negedge clk);
        rd("R7 idle holds", 4'h0, 32'd6);

        // R6 stop freezes count
        kwr(4'h8, 32'd0);
        pulse_tick(2);
        rd("R6 stopped count", 4'h0, 32'd6);
        rd("R6 enable cleared", 4'h8, 32'd0);
        kwr(4'h8, 32'd1);

        // R9 warning one cycle after count meets threshold 3
        pulse_tick(3);
        check("R9 warn not yet", {31'd0, irq_warn}, 32'd0);
        @(negedge clk);
        check("R9 warn set", {31'd0, irq_warn}, 32'd1);
        check("R9 status bit 8", status, 32'h0000_0100);

        // R10 clear loses to a condition that still holds
        pulse_clr(32'h0000_0100);
        check("R10 set wins", {31'd0, irq_warn}, 32'd1);
        pulse_tick(1);
        @(negedge clk);
        pulse_clr(32'h0000_0100);
        check("R10 cleared", status, 32'd0);

        // R5 keep-alive then R8 expiry
        kwr(4'h0, 32'd2);
        rd("R5 keep-alive", 4'h0, 32'd2);
        pulse_tick(2);
        check("R8 expire not yet", {31'd0, irq_expire}, 32'd0);
        @(negedge clk);
        check("R8 expire set", {31'd0, irq_expire}, 32'd1);
        check("R8 status bit 9", status, 32'h0000_0200);
        pulse_tick(3);
        rd("R7 holds at zero", 4'h0, 32'd0);

        pulse_clr(32'h0000_0200);
        check("R10 expire held while zero", {31'd0, irq_expire}, 32'd1);
        kwr(4'h0, 32'd100);
        pulse_clr(32'h0000_0200);
        check("R10 expire cleared", status, 32'd0);

        // R9 zero threshold gives no warning
        kwr(4'h4, 32'd0);
        kwr(4'h0, 32'd2);
        pulse_tick(2);
        @(negedge clk);
        check("R9 zero threshold no warn", {31'd0, irq_warn}, 32'd0);
        check("R8 expire after zero-thr run", {31'd0, irq_expire}, 32'd1);

        // R5 maximum load
        kwr(4'h0, 32'hFFFF_FFFF);
        rd("R5 max load", 4'h0, 32'hFFFF_FFFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule